// File: doc/BRIEF.md
# Dual Programmable Clock-Enable Generator

This block derives timing strobes for a bank of pulse-width counters from a single master clock. Nothing in it is a derived clock. Every output is an enable that stays high for exactly one master-clock cycle, so all downstream logic stays in one clock domain.

A free-running binary prescaler provides eleven power-of-two taps, from the master rate (every cycle) down to one pulse per 1024 cycles. Two independent generators, A and B, each pick one prescaler tap and count its pulses. A generator emits one strobe every N tap pulses, where N is an 8-bit factor. Both generators are programmed through one 32-bit configuration word, and a write strobe loads that word.

Each channel owns a 4-bit source code. The code routes one of three things to that channel's enable output: a prescaler tap, generator A, or generator B.

Top module: `pwm_clk_enables`

## Requirements
- R1: After reset, both generator outputs are low and stay low until a configuration word is written. A channel whose code selects a generator is therefore also low.
- R2: Prescaler tap k (k = 0..10) pulses high for one cycle once every 2^k master cycles. Tap 0 is high in every cycle.
- R3: Whenever tap k (k ≥ 1) is high, tap k-1 is high in the same cycle.
- R4: Generator A reads its divide factor D from bits 7:0 of the configuration word and its tap index P from bits 11:8. When enabled, it strobes once every D·2^P master cycles, and only in a cycle where tap P is high.
- R5: Generator B reads its divide factor from bits 23:16 and its tap index from bits 27:24. It otherwise behaves as in R4.
- R6: A generator whose divide factor is 0, or whose tap index is 11..15, emits no strobe.
- R7: A configuration write restarts both generators' counts from zero. With tap index 0 and factor D, the first strobe appears in the D-th cycle after the write edge. For D > 1, no strobe appears in the first cycle after the write.
- R8: In a cycle where the write strobe is high, neither generator output is high. This applies even if that cycle would otherwise end a count.
- R9: Channel source code 0..10 selects the prescaler tap with that index, code 11 selects generator A, code 12 selects generator B, and codes 13..15 hold the channel enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Configuration write strobe |
| mode_wdata | input | 32 | Configuration word (A: factor 7:0, tap 11:8; B: factor 23:16, tap 27:24) |
| chan_sel | input | 4·NCH | Per-channel source code, channel i at bits 4i+3:4i |
| tap_en | output | 11 | Prescaler tap strobes, bit k = master/2^k |
| clka_en | output | 1 | Generator A strobe |
| clkb_en | output | 1 | Generator B strobe |
| chan_en | output | NCH | Per-channel routed enable |

## Verification
A configuration write and a generator's terminal count can fall in the same cycle. The write must win: the strobe is muted and the count restarts.

To provoke this case, the bench first sets generator A to tap 0 with factor 1, so it fires in every cycle. It then raises the write strobe for one cycle. The bench expects A to be low in that cycle and high again in the cycle after it.

A bound property also requires both generator outputs to be low whenever the write strobe is high, over the whole run.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NTAP  = 11;   // power-of-two taps, index 0..10
  localparam int CNTW  = NTAP - 1;
  localparam int DVW   = 8;    // linear divide factor width
  localparam int PSW   = 4;    // tap index / source code width
  localparam logic [PSW-1:0] SRC_GEN_A = 4'd11;
  localparam logic [PSW-1:0] SRC_GEN_B = 4'd12;

  // Tap k fires when the low k bits of the prescaler count are all ones.
  function automatic logic tap_hit(input logic [CNTW-1:0] cnt, input int k);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < CNTW; i++) begin
      if (i < k && !cnt[i]) hit = 1'b0;
    end
    return hit;
  endfunction

  function automatic logic tap_valid(input logic [PSW-1:0] idx);
    return int'(idx) < NTAP;
  endfunction

  function automatic logic pick_tap(input logic [NTAP-1:0] taps,
                                    input logic [PSW-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NTAP; i++) begin
      if (int'(idx) == i) r = taps[i];
    end
    return r;
  endfunction

  function automatic logic route_src(input logic [PSW-1:0] code,
                                     input logic [NTAP-1:0] taps,
                                     input logic ga, input logic gb);
    if (tap_valid(code)) return pick_tap(taps, code);
    if (code == SRC_GEN_A) return ga;
    if (code == SRC_GEN_B) return gb;
    return 1'b0;
  endfunction
endpackage

// File: rtl/prescale_chain.sv
module prescale_chain
  import clkdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] taps
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign taps[k] = tap_hit(cnt_q, k);
  end
endmodule

// File: rtl/div_gen.sv
module div_gen
  import clkdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [DVW-1:0]  div,
  input  logic [PSW-1:0]  psel,
  input  logic [NTAP-1:0] taps,
  output logic            strobe
);
  logic [DVW-1:0] cnt_q;
  logic active, step, at_end, fire;

  assign active = (div != '0) && tap_valid(psel);
  assign step   = active && pick_tap(taps, psel);
  assign at_end = (cnt_q == div - 1'b1);
  assign fire   = step && at_end;
  assign strobe = fire && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (step)         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_route.sv
module clk_route
  import clkdiv_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH*PSW-1:0] sel,
  input  logic [NTAP-1:0]    taps,
  input  logic               gen_a,
  input  logic               gen_b,
  output logic [NCH-1:0]     en
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign en[i] = route_src(sel[i*PSW +: PSW], taps, gen_a, gen_b);
  end
endmodule

// File: rtl/pwm_clk_enables.sv
module pwm_clk_enables
  import clkdiv_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [31:0]        mode_wdata,
  input  logic [NCH*PSW-1:0] chan_sel,
  output logic [NTAP-1:0]    tap_en,
  output logic               clka_en,
  output logic               clkb_en,
  output logic [NCH-1:0]     chan_en
);
  localparam int A_DIV_LSB = 0;
  localparam int A_TAP_LSB = 8;
  localparam int B_DIV_LSB = 16;
  localparam int B_TAP_LSB = 24;

  logic [DVW-1:0] a_div, b_div;
  logic [PSW-1:0] a_psel, b_psel;
  logic           unused_mode_bits;

  assign unused_mode_bits = ^{mode_wdata[15:12], mode_wdata[31:28]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_div <= '0; a_psel <= '0; b_div <= '0; b_psel <= '0;
    end else if (mode_wr) begin
      a_div  <= mode_wdata[A_DIV_LSB +: DVW];
      a_psel <= mode_wdata[A_TAP_LSB +: PSW];
      b_div  <= mode_wdata[B_DIV_LSB +: DVW];
      b_psel <= mode_wdata[B_TAP_LSB +: PSW];
    end
  end

  prescale_chain u_pre (.clk(clk), .rst_n(rst_n), .taps(tap_en));

  div_gen u_gen_a (.clk(clk), .rst_n(rst_n), .restart(mode_wr),
                   .div(a_div), .psel(a_psel), .taps(tap_en), .strobe(clka_en));
  div_gen u_gen_b (.clk(clk), .rst_n(rst_n), .restart(mode_wr),
                   .div(b_div), .psel(b_psel), .taps(tap_en), .strobe(clkb_en));

  clk_route #(.NCH(NCH)) u_route (.sel(chan_sel), .taps(tap_en),
                                  .gen_a(clka_en), .gen_b(clkb_en), .en(chan_en));
endmodule

// File: rtl/pwm_clk_enables_chk.sv
module pwm_clk_enables_chk
  import clkdiv_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_wr,
  input logic [NCH*PSW-1:0] chan_sel,
  input logic [NTAP-1:0]    tap_en,
  input logic               clka_en,
  input logic               clkb_en,
  input logic [NCH-1:0]     chan_en,
  input logic [DVW-1:0]     a_div,
  input logic [PSW-1:0]     a_psel,
  input logic [DVW-1:0]     b_div,
  input logic [PSW-1:0]     b_psel
);
  assert_tap0_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_en[0]);

  for (genvar k = 1; k < NTAP; k++) begin : g_nest
    assert_tap_nest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tap_en[k] |-> tap_en[k-1]);
  end

  assert_gen_a_on_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clka_en |-> (int'(a_psel) < NTAP) && tap_en[a_psel]);
  assert_gen_b_on_tap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clkb_en |-> (int'(b_psel) < NTAP) && tap_en[b_psel]);

  assert_gen_a_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_div == '0 || int'(a_psel) >= NTAP) |-> !clka_en);
  assert_gen_b_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_div == '0 || int'(b_psel) >= NTAP) |-> !clkb_en);

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !$past(mode_wr)) |=> (a_div > 8'd1 |-> !clka_en));

  assert_write_mutes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> (!clka_en && !clkb_en));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_route_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_sel[i*PSW +: PSW] == SRC_GEN_A) |-> (chan_en[i] == clka_en));
    assert_route_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_sel[i*PSW +: PSW] == SRC_GEN_B) |-> (chan_en[i] == clkb_en));
    assert_route_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(chan_sel[i*PSW +: PSW]) > 12) |-> !chan_en[i]);
  end
endmodule

bind pwm_clk_enables pwm_clk_enables_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .chan_sel(chan_sel),
  .tap_en(tap_en), .clka_en(clka_en), .clkb_en(clkb_en), .chan_en(chan_en),
  .a_div(a_div), .a_psel(a_psel), .b_div(b_div), .b_psel(b_psel));

// File: tb/test_pwm_clk_enables.sv
module test_pwm_clk_enables;
  localparam int NCH = 4;
  localparam int NT  = 11;
  localparam int NVEC = 6;
  localparam int WIN  = 6000;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0105_0003, 32'h0302_0207, 32'h00FF_0001,
    32'h0A02_0401, 32'h0004_0510, 32'h0B03_0000 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic [NCH*4-1:0] chan_sel = '0;
  logic [NT-1:0] tap_en;
  logic clka_en, clkb_en;
  logic [NCH-1:0] chan_en;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_clk_enables #(.NCH(NCH)) i_pwm_clk_enables (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .chan_sel(chan_sel), .tap_en(tap_en), .clka_en(clka_en), .clkb_en(clkb_en),
    .chan_en(chan_en));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input logic [7:0] d, input logic [3:0] p);
    if (d == 0 || p > 4'd10) return 0;
    return int'(d) * (1 << p);
  endfunction

  task automatic write_mode(input logic [31:0] w);
    @(posedge clk); #1;
    mode_wr = 1'b1; mode_wdata = w;
    @(posedge clk); #1;
    mode_wr = 1'b0;
  endtask

  task automatic watch(output int na, output int fa, output int ga,
                       output int nb, output int fb, output int gb);
    na = 0; fa = -1; ga = 0; nb = 0; fb = -1; gb = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (clka_en) begin
        if (na == 0) fa = k; else if (na == 1) ga = k - fa;
        na++;
      end
      if (clkb_en) begin
        if (nb == 0) fb = k; else if (nb == 1) gb = k - fb;
        nb++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int na, fa, ga, nb, fb, gb;
    int pa, pb;
    int hits [NT];
    int nest_bad, mis0, mis1, mis2, mis3;

    // R1: reset state, generator-routed channels idle
    chan_sel = {4'd14, 4'd12, 4'd11, 4'd3};
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    nb = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (clka_en || clkb_en || chan_en[1] || chan_en[2]) nb++;
    end
    check(nb == 0, "R1 generators idle after reset", nb, 0);
    check(tap_en[0] == 1'b1, "R2 tap0 high after reset", tap_en[0], 1);

    // R2/R3: tap rates and nesting over a 64-cycle window
    for (int t = 0; t < NT; t++) hits[t] = 0;
    nest_bad = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      for (int t = 0; t < NT; t++) if (tap_en[t]) hits[t]++;
      for (int t = 1; t < NT; t++) if (tap_en[t] && !tap_en[t-1]) nest_bad++;
    end
    for (int t = 0; t <= 6; t++)
      check(hits[t] == (64 >> t), $sformatf("R2 tap %0d pulses in 64", t), hits[t], 64 >> t);
    check(nest_bad == 0, "R3 tap nesting", nest_bad, 0);

    // R4/R5/R6/R7: table of configuration words
    for (int v = 0; v < NVEC; v++) begin
      pa = period_of(VEC[v][7:0], VEC[v][11:8]);
      pb = period_of(VEC[v][23:16], VEC[v][27:24]);
      write_mode(VEC[v]);
      watch(na, fa, ga, nb, fb, gb);
      if (pa == 0) check(na == 0, $sformatf("R6 A stopped vec %0d", v), na, 0);
      else         check(na >= 2 && ga == pa, $sformatf("R4 A period vec %0d", v), ga, pa);
      if (pb == 0) check(nb == 0, $sformatf("R6 B stopped vec %0d", v), nb, 0);
      else         check(nb >= 2 && gb == pb, $sformatf("R5 B period vec %0d", v), gb, pb);
      if (pa != 0 && VEC[v][11:8] == 4'd0)
        check(fa == int'(VEC[v][7:0]) - 1, $sformatf("R7 A first strobe vec %0d", v), fa, int'(VEC[v][7:0]) - 1);
      if (pb != 0 && VEC[v][27:24] == 4'd0)
        check(fb == int'(VEC[v][23:16]) - 1, $sformatf("R7 B first strobe vec %0d", v), fb, int'(VEC[v][23:16]) - 1);
    end

    // R7: restart in mid count (A tap0 factor 5)
    write_mode(32'h0000_0005);
    repeat (3) @(negedge clk);
    write_mode(32'h0000_0005);
    watch(na, fa, ga, nb, fb, gb);
    check(fa == 4, "R7 restart mid count", fa, 4);

    // R8: write coincides with terminal count
    write_mode(32'h0000_0001);
    @(negedge clk);
    check(clka_en == 1'b1, "R8 A strobes every cycle before write", clka_en, 1);
    @(posedge clk); #1;
    mode_wr = 1'b1;
    @(negedge clk);
    check(clka_en == 1'b0, "R8 strobe muted in write cycle", clka_en, 0);
    @(posedge clk); #1;
    mode_wr = 1'b0;
    @(negedge clk);
    check(clka_en == 1'b1, "R8 strobe resumes after write", clka_en, 1);

    // R9: channel routing
    write_mode(32'h0102_0003);
    mis0 = 0; mis1 = 0; mis2 = 0; mis3 = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (chan_en[0] != tap_en[3]) mis0++;
      if (chan_en[1] != clka_en)   mis1++;
      if (chan_en[2] != clkb_en)   mis2++;
      if (chan_en[3] != 1'b0)      mis3++;
    end
    check(mis0 == 0, "R9 code 3 routes tap 3", mis0, 0);
    check(mis1 == 0, "R9 code 11 routes A", mis1, 0);
    check(mis2 == 0, "R9 code 12 routes B", mis2, 0);
    check(mis3 == 0, "R9 code 14 held low", mis3, 0);
    chan_sel = {4'd0, 4'd10, 4'd13, 4'd15};
    mis0 = 0; mis1 = 0;
    for (int k = 0; k < 2100; k++) begin
      @(negedge clk);
      if (chan_en[0] || chan_en[1]) mis0++;
      if (chan_en[2] != tap_en[10] || chan_en[3] != 1'b1) mis1++;
    end
    check(mis0 == 0, "R9 codes 15 and 13 held low", mis0, 0);
    check(mis1 == 0, "R9 codes 10 and 0 route taps", mis1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule